// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block decides when an automatic offset calibration may run, and it times that run. A calibration starts only when software has armed it. The single-wire host line must also be idle low, and a comparator must report that the sensed input is below the wake threshold. The entry conditions have to hold for a qualification period of more than ten ticks of a 1 Hz timebase. After that, a 3600-tick measurement window opens. If the conditions hold for the whole window, the offset value from the measurement path is captured into the offset register. The arming bit and the override bit then clear themselves, and the block shows a low-power rest state until the host line goes high again.

If any condition drops during qualification or during the window, the run is abandoned. Nothing is captured, and the block waits in idle until the conditions return. It then starts qualification again from zero. Software can set an override bit so that the line level no longer matters. The threshold comparator then gates the run on its own. The analog measurement that produces the offset value lies outside this block. The block only decides the cycle in which that value is taken.

Top module: `ofs_cal_seq`

## Requirements
- R1: While reset is held and right after it, `ofs_q` is 0, and `cal_en`, `ovr_en`, `low_pwr` and `cal_active` are all 0.
- R2: When `wr_stb` is high at a clock edge, `cal_en` takes the value of `wr_cal_en` and `ovr_en` takes the value of `wr_ovr`, both visible after that edge.
- R3: From idle, with `cal_en` set and the entry condition true, the block begins qualifying at the next edge. `cal_active` rises after the edge that samples the 11th tick (QUAL_TICKS+1) of uninterrupted qualification, and not before.
- R4: The window completes when it has seen WIN_TICKS ticks (3600) with the entry condition holding. After the edge that samples the last tick, `ofs_q` equals the `meas_ofs` value at that edge, and `cal_en` and `ovr_en` are 0.
- R5: While qualifying or inside the window, a high `line_hi` (with `ovr_en` at 0) or a low `below_thr` returns the block to idle one edge later. A later run counts its qualification ticks from zero again.
- R6: An abandoned run leaves `ofs_q` and `cal_en` unchanged. `ofs_q` changes only at a completed window.
- R7: With `ovr_en` at 1, the level of `line_hi` has no effect on qualification or on the window. Only `below_thr` and `cal_en` gate the run.
- R8: `low_pwr` is set after a completed window and stays set while `line_hi` is low. It clears one edge after `line_hi` is sampled high.
- R9: With `cal_en` at 0 no run starts. Clearing `cal_en` during a run abandons it one edge after the write takes effect.
- R10: Qualification and window progress advance only on edges where `tick` is high. Edges without a tick leave the run where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable per second of the 1 Hz timebase |
| wr_stb | input | 1 | Host write strobe for the two control bits |
| wr_cal_en | input | 1 | Value written to the arming bit |
| wr_ovr | input | 1 | Value written to the override bit |
| line_hi | input | 1 | Level of the single-wire host line |
| below_thr | input | 1 | Comparator: sensed input magnitude below wake threshold |
| meas_ofs | input | OFS_W | Offset value from the measurement path |
| ofs_q | output | OFS_W | Latched calibration offset |
| cal_en | output | 1 | Arming bit, cleared by a completed window |
| ovr_en | output | 1 | Line-idle override bit, cleared by a completed window |
| low_pwr | output | 1 | Rest indication after a completed window |
| cal_active | output | 1 | Measurement window in progress |

## Verification
Every output is a register, so each result is due exactly one clock edge after the inputs that cause it. This covers the bit writes, the rise of `cal_active` on the qualifying tick, the capture and self-clear on the final window tick, an abort on a failed condition, and the exit from rest on a high line. Inputs are driven on the falling edge. A behavioural model advances on the rising edge from the same inputs, and every output is compared with it on the next falling edge. This places each comparison half a cycle after the edge that must produce the change. Directed checks at tick counts 10 and 11 of qualification, and at 3599 and 3600 of the window, pin the boundaries from both sides.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_QUAL = 2'd1,
    PH_WIN  = 2'd2,
    PH_REST = 2'd3
  } cal_phase_t;

  // entry condition: input below threshold, and line idle low unless overridden
  function automatic logic f_gate_ok(input logic below_thr,
                                     input logic line_hi,
                                     input logic ovr);
    return below_thr && (ovr || !line_hi);
  endfunction

  // a limit is reached on the tick that finds the counter at the limit value
  function automatic logic f_limit_hit(input logic        tick,
                                       input logic [31:0] cnt,
                                       input logic [31:0] lim);
    return tick && (cnt == lim);
  endfunction

endpackage

// File: rtl/ofs_cal_cfg.sv
module ofs_cal_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_cal_en,
  input  logic wr_ovr,
  input  logic done_evt,
  output logic cal_en,
  output logic ovr_en
);

  // completion clears both bits; it outranks a host write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_en <= 1'b0;
      ovr_en <= 1'b0;
    end else if (done_evt) begin
      cal_en <= 1'b0;
      ovr_en <= 1'b0;
    end else if (wr_stb) begin
      cal_en <= wr_cal_en;
      ovr_en <= wr_ovr;
    end
  end

  AST_EN_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_en) |-> ($past(done_evt) || $past(wr_stb && !wr_cal_en))); // R6

  AST_OVR_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_en) |-> ($past(done_evt) || $past(wr_stb && !wr_ovr))); // R4

endmodule

// File: rtl/ofs_cal_timer.sv
module ofs_cal_timer #(
  parameter int CNT_W   = 12,
  parameter int CNT_MAX = 3600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);

  logic at_top;
  assign at_top = (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick && !at_top) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_TOP); // R10

endmodule

// File: rtl/ofs_cal_fsm.sv
module ofs_cal_fsm
  import ofs_cal_pkg::*;
#(
  parameter int QUAL_TICKS = 10,
  parameter int WIN_TICKS  = 3600,
  parameter int CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             ovr_en,
  input  logic             line_hi,
  input  logic             below_thr,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  output cal_phase_t       phase,
  output logic             tmr_clr,
  output logic             done_evt
);

  localparam logic [31:0] QUAL_LIM = 32'(QUAL_TICKS);
  localparam logic [31:0] WIN_LIM  = 32'(WIN_TICKS - 1);

  cal_phase_t phase_nx;
  logic       gate_ok;
  logic       in_run;
  logic       qual_hit;
  logic       win_hit;
  logic       abort_evt;

  assign gate_ok   = cal_en && f_gate_ok(below_thr, line_hi, ovr_en);
  assign in_run    = (phase == PH_QUAL) || (phase == PH_WIN);
  assign qual_hit  = f_limit_hit(tick, 32'(cnt), QUAL_LIM);
  assign win_hit   = f_limit_hit(tick, 32'(cnt), WIN_LIM);
  assign abort_evt = in_run && !gate_ok;
  assign done_evt  = (phase == PH_WIN) && gate_ok && win_hit;
  assign tmr_clr   = (phase == PH_IDLE) || (phase == PH_REST) || abort_evt ||
                     ((phase == PH_QUAL) && qual_hit);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (gate_ok) phase_nx = PH_QUAL;
      PH_QUAL: begin
        if (!gate_ok)      phase_nx = PH_IDLE;
        else if (qual_hit) phase_nx = PH_WIN;
      end
      PH_WIN: begin
        if (!gate_ok)     phase_nx = PH_IDLE;
        else if (win_hit) phase_nx = PH_REST;
      end
      PH_REST: if (line_hi) phase_nx = PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  AST_WIN_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_WIN) |-> $past(phase == PH_QUAL)); // R3

  AST_ABORT_ON_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !below_thr) |=> (phase == PH_IDLE)); // R5

  AST_ABORT_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && line_hi && !ovr_en) |=> (phase == PH_IDLE)); // R5

  AST_NO_START_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && !cal_en) |=> (phase == PH_IDLE)); // R9

  AST_NO_TICK_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_QUAL) && cal_en && below_thr && !line_hi && !tick)
      |=> (phase == PH_QUAL)); // R10

  AST_REST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_REST) && !line_hi) |=> (phase == PH_REST)); // R8

  AST_REST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_REST) && line_hi) |=> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
  import ofs_cal_pkg::*;
#(
  parameter int OFS_W      = 8,
  parameter int QUAL_TICKS = 10,
  parameter int WIN_TICKS  = 3600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_stb,
  input  logic             wr_cal_en,
  input  logic             wr_ovr,
  input  logic             line_hi,
  input  logic             below_thr,
  input  logic [OFS_W-1:0] meas_ofs,
  output logic [OFS_W-1:0] ofs_q,
  output logic             cal_en,
  output logic             ovr_en,
  output logic             low_pwr,
  output logic             cal_active
);

  localparam int CNT_W = $clog2(WIN_TICKS + 1);

  cal_phase_t       phase;
  logic             tmr_clr;
  logic             done_evt;
  logic [CNT_W-1:0] sec_cnt;

  ofs_cal_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_cal_en (wr_cal_en),
    .wr_ovr    (wr_ovr),
    .done_evt  (done_evt),
    .cal_en    (cal_en),
    .ovr_en    (ovr_en)
  );

  ofs_cal_timer #(
    .CNT_W   (CNT_W),
    .CNT_MAX (WIN_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (tick),
    .cnt   (sec_cnt)
  );

  ofs_cal_fsm #(
    .QUAL_TICKS (QUAL_TICKS),
    .WIN_TICKS  (WIN_TICKS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_en    (cal_en),
    .ovr_en    (ovr_en),
    .line_hi   (line_hi),
    .below_thr (below_thr),
    .tick      (tick),
    .cnt       (sec_cnt),
    .phase     (phase),
    .tmr_clr   (tmr_clr),
    .done_evt  (done_evt)
  );

  // offset register: written only by a completed window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ofs_q <= '0;
    else if (done_evt) ofs_q <= meas_ofs;
  end

  assign low_pwr    = (phase == PH_REST);
  assign cal_active = (phase == PH_WIN);

  AST_OFS_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofs_q) |-> $past(done_evt)); // R6

  AST_DONE_CLEARS_AND_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!cal_en && !ovr_en && low_pwr)); // R4

  AST_REST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_pwr && cal_active)); // R8

endmodule

// File: tb/ofs_cal_seq_tb.sv
module ofs_cal_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_W      = 8;
  localparam int QUAL_TICKS = 10;
  localparam int WIN_TICKS  = 3600;
  localparam int WD_LIMIT   = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             wr_stb = 1'b0;
  logic             wr_cal_en = 1'b0;
  logic             wr_ovr = 1'b0;
  logic             line_hi = 1'b1;
  logic             below_thr = 1'b1;
  logic [OFS_W-1:0] meas_ofs = '0;
  logic [OFS_W-1:0] ofs_q;
  logic             cal_en;
  logic             ovr_en;
  logic             low_pwr;
  logic             cal_active;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_cal_seq #(
    .OFS_W      (OFS_W),
    .QUAL_TICKS (QUAL_TICKS),
    .WIN_TICKS  (WIN_TICKS)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_stb     (wr_stb),
    .wr_cal_en  (wr_cal_en),
    .wr_ovr     (wr_ovr),
    .line_hi    (line_hi),
    .below_thr  (below_thr),
    .meas_ofs   (meas_ofs),
    .ofs_q      (ofs_q),
    .cal_en     (cal_en),
    .ovr_en     (ovr_en),
    .low_pwr    (low_pwr),
    .cal_active (cal_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // mode: "idle", "qualify", "window", "rest"; secs counts ticks seen in a mode
  string m_mode = "idle";
  int    m_secs = 0;
  bit    m_en = 0, m_ovr = 0;
  int    m_ofs = 0;

  always @(posedge clk) begin
    bit ok, finished;
    if (!rst_n) begin
      m_mode = "idle"; m_secs = 0; m_en = 0; m_ovr = 0; m_ofs = 0;
    end else begin
      ok = m_en && below_thr && (m_ovr || !line_hi);
      finished = 0;
      if (m_mode == "idle") begin
        if (ok) begin m_mode = "qualify"; m_secs = 0; end
      end else if (m_mode == "qualify") begin
        if (!ok) m_mode = "idle";
        else if (tick) begin
          m_secs++;
          if (m_secs > QUAL_TICKS) begin m_mode = "window"; m_secs = 0; end
        end
      end else if (m_mode == "window") begin
        if (!ok) m_mode = "idle";
        else if (tick) begin
          m_secs++;
          if (m_secs == WIN_TICKS) begin m_mode = "rest"; finished = 1; end
        end
      end else begin
        if (line_hi) m_mode = "idle";
      end
      if (finished) begin
        m_en = 0; m_ovr = 0; m_ofs = int'(meas_ofs);
      end else if (wr_stb) begin
        m_en = wr_cal_en; m_ovr = wr_ovr;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R4/R6 ofs_q vs model", int'(ofs_q), m_ofs);
      chk("R2/R4 cal_en vs model", int'(cal_en), int'(m_en));
      chk("R2/R7 ovr_en vs model", int'(ovr_en), int'(m_ovr));
      chk("R8 low_pwr vs model", int'(low_pwr), int'(m_mode == "rest"));
      chk("R3/R5 cal_active vs model", int'(cal_active), int'(m_mode == "window"));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic host_wr(input logic en, input logic ov);
    @(negedge clk);
    wr_stb = 1'b1; wr_cal_en = en; wr_ovr = ov;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset values
    chk("R1 ofs_q in reset", int'(ofs_q), 0);
    chk("R1 low_pwr in reset", int'(low_pwr), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 ofs_q after reset", int'(ofs_q), 0);
    chk("R1 cal_en after reset", int'(cal_en), 0);
    chk("R1 ovr_en after reset", int'(ovr_en), 0);
    chk("R1 cal_active after reset", int'(cal_active), 0);

    // normal run with line low
    line_hi = 1'b0; meas_ofs = 8'h5A;
    host_wr(1'b1, 1'b0);
    chk("R2 cal_en set by write", int'(cal_en), 1);
    chk("R2 ovr_en written 0", int'(ovr_en), 0);
    idle(2);
    ticks(QUAL_TICKS);
    chk("R3 not active after 10 ticks", int'(cal_active), 0);
    ticks(1);
    chk("R3 active after 11th tick", int'(cal_active), 1);
    idle(5);
    chk("R10 no ticks keeps window", int'(cal_active), 1);
    ticks(WIN_TICKS - 1);
    chk("R4 not done at 3599", int'(low_pwr), 0);
    chk("R4 ofs unchanged at 3599", int'(ofs_q), 0);
    ticks(1);
    chk("R4 ofs captured", int'(ofs_q), 32'h5A);
    chk("R4 cal_en self-cleared", int'(cal_en), 0);
    chk("R8 low_pwr after done", int'(low_pwr), 1);
    idle(5);
    chk("R8 low_pwr held while line low", int'(low_pwr), 1);
    line_hi = 1'b1;
    idle(1);
    chk("R8 low_pwr clears on line high", int'(low_pwr), 0);

    // aborts
    line_hi = 1'b0; meas_ofs = 8'hC3;
    host_wr(1'b1, 1'b0);
    idle(2);
    ticks(QUAL_TICKS + 1);
    chk("R3 active in second run", int'(cal_active), 1);
    ticks(100);
    line_hi = 1'b1;
    idle(1);
    chk("R5 line high aborts", int'(cal_active), 0);
    chk("R6 cal_en kept on abort", int'(cal_en), 1);
    chk("R6 ofs kept on abort", int'(ofs_q), 32'h5A);
    line_hi = 1'b0;
    idle(2);
    idle(6);
    ticks(QUAL_TICKS);
    chk("R5 restart counts from zero", int'(cal_active), 0);
    ticks(1);
    chk("R5 restart reaches window", int'(cal_active), 1);
    ticks(WIN_TICKS - 1);
    below_thr = 1'b0;
    idle(1);
    chk("R5 threshold aborts late window", int'(cal_active), 0);
    chk("R6 ofs kept on late abort", int'(ofs_q), 32'h5A);
    chk("R6 cal_en kept on late abort", int'(cal_en), 1);
    below_thr = 1'b1;
    idle(2);

    // override: line level ignored
    meas_ofs = 8'h33;
    host_wr(1'b1, 1'b1);
    line_hi = 1'b1;
    idle(2);
    ticks(QUAL_TICKS + 1);
    chk("R7 window with line high under override", int'(cal_active), 1);
    ticks(WIN_TICKS);
    chk("R7 ofs captured under override", int'(ofs_q), 32'h33);
    chk("R7 ovr_en self-cleared", int'(ovr_en), 0);
    chk("R8 low_pwr after override run", int'(low_pwr), 1);
    idle(1);
    chk("R8 low_pwr exits with line high", int'(low_pwr), 0);

    // disarmed
    line_hi = 1'b0;
    ticks(20);
    chk("R9 no run while disarmed", int'(cal_active), 0);
    chk("R9 no rest while disarmed", int'(low_pwr), 0);
    host_wr(1'b1, 1'b0);
    idle(2);
    ticks(QUAL_TICKS + 1);
    chk("R9 armed run starts", int'(cal_active), 1);
    host_wr(1'b0, 1'b0);
    idle(1);
    chk("R9 disarm aborts run", int'(cal_active), 0);
    chk("R6 ofs kept after disarm", int'(ofs_q), 32'h33);
    idle(4);

    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule